// File: doc/BRIEF.md
# Shared Interrupt Link Router

This block steers eight shared, level-sensitive interrupt links onto a bank of sixteen legacy IRQ lines. Each link collects a small group of device request wires. The link counts as active while any wire in its group is high. A per-link route byte decides where an active link goes. The route byte holds a disable flag and a 4-bit target IRQ number. A link drives its target line only when the flag is clear and the number is on the permitted list. Several links may share one line, and that line stays high while any of them is active.

Configuration software reaches the route bytes through a small register port. Index value k on the port selects link k+1, so links are numbered 1 to 8. The port has no back-pressure: every write and read strobe is accepted in the cycle it is presented, and no ready signal exists. The IRQ outputs are registered once. A request change or a route rewrite therefore appears on the lines one clock later, and the old target line and the new target line change in the same cycle.

Top module: `irq_link_router`

## Requirements
- R1: After reset every route byte reads 0x80 (disabled, target 0) and all sixteen `irq_out` bits are low.
- R2: A write stores bit 7 (disable flag) and bits 3:0 (target IRQ) of `cfg_wdata` into the link chosen by `cfg_link`. Bits 6:4 are dropped and read back as zero. Read data for `cfg_link` appears on `cfg_rdata` in the cycle after `cfg_rd_en` and holds while no read is issued.
- R3: Link k (index k, 0..7) uses request bits `dev_req[k*4+3 : k*4]`. The link is active while any of those bits is 1. It asserts on the first requester and releases only when the last requester drops.
- R4: `irq_out[i]` is high one clock after some link is active, enabled and routed to permitted IRQ i. With no active link, all outputs are low.
- R5: A route whose target is 0, 1, 2, 8 or 13 (permit mask 0xDEF8) drives no output, just as a disabled route does.
- R6: A route with bit 7 set drives no output, whatever its target field holds.
- R7: Links routed to the same IRQ share it. The line stays high until every such link is inactive.
- R8: Rewriting the route of an active link moves its assertion. One clock after the write takes effect, the old line drops and the new valid line rises in the same cycle.
- R9: Rewriting a route with its current value leaves every output unchanged in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Route write strobe |
| cfg_rd_en | input | 1 | Route read strobe |
| cfg_link | input | 3 | Link index (value k selects link k+1) |
| cfg_wdata | input | 8 | Route byte to write |
| cfg_rdata | output | 8 | Route byte read, valid the cycle after `cfg_rd_en` |
| dev_req | input | 32 | Device requests, 4 per link, link k in bits k*4+3:k*4 |
| irq_out | output | 16 | Routed level IRQ lines |

## Verification
The bench builds the router with its defaults: eight links, four requesters per link, sixteen lines and permit mask 0xDEF8. With these values every reserved target number and every link index can be tried. Each request bit position is within reach too, so the per-link grouping and the sharing of one line by two links are checked exactly. Setting four requesters per link lets the bench hold two requesters of one link high and drop them one at a time, which tests release on the last requester.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int unsigned IRQ_NUM_W = 4;

  typedef struct packed {
    logic                 dis;
    logic [IRQ_NUM_W-1:0] num;
  } route_t;

  localparam route_t ROUTE_RESET = '{dis: 1'b1, num: '0};

  function automatic logic [7:0] route_to_byte(input route_t r);
    return {r.dis, 3'b000, r.num};
  endfunction

  function automatic route_t byte_to_route(input logic [7:0] b);
    route_t r;
    r.dis = b[7];
    r.num = b[IRQ_NUM_W-1:0];
    return r;
  endfunction
endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_LINKS = 8,
  localparam int unsigned IDX_W = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [IDX_W-1:0]         idx,
  input  logic [7:0]               wdata,
  output logic [7:0]               rdata,
  output route_t [NUM_LINKS-1:0]   routes
);
  genvar g;
  generate
    for (g = 0; g < NUM_LINKS; g++) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          routes[g] <= ROUTE_RESET;
        end else if (wr_en && (idx == IDX_W'(g))) begin
          routes[g] <= byte_to_route(wdata);
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= (32'(idx) < NUM_LINKS) ? route_to_byte(routes[idx]) : 8'h00;
    end
  end
endmodule

// File: rtl/irq_link_activity.sv
module irq_link_activity #(
  parameter int unsigned NUM_LINKS     = 8,
  parameter int unsigned REQS_PER_LINK = 4
) (
  input  logic [NUM_LINKS*REQS_PER_LINK-1:0] dev_req,
  output logic [NUM_LINKS-1:0]               link_active
);
  genvar g;
  generate
    for (g = 0; g < NUM_LINKS; g++) begin : g_or
      assign link_active[g] = |dev_req[g*REQS_PER_LINK +: REQS_PER_LINK];
    end
  endgenerate
endmodule

// File: rtl/irq_line_fanout.sv
module irq_line_fanout
  import irq_router_pkg::*;
#(
  parameter int unsigned       NUM_LINKS   = 8,
  parameter int unsigned       NUM_IRQS    = 16,
  parameter logic [NUM_IRQS-1:0] PERMIT_MASK = 16'hDEF8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  route_t [NUM_LINKS-1:0] routes,
  input  logic [NUM_LINKS-1:0]   link_active,
  output logic [NUM_IRQS-1:0]    irq_out
);
  logic [NUM_LINKS-1:0] link_live;
  logic [NUM_IRQS-1:0]  irq_next;

  genvar g;
  generate
    for (g = 0; g < NUM_LINKS; g++) begin : g_live
      assign link_live[g] = link_active[g] && !routes[g].dis &&
                            (32'(routes[g].num) < NUM_IRQS) &&
                            PERMIT_MASK[routes[g].num];
    end
  endgenerate

  always_comb begin
    irq_next = '0;
    for (int i = 0; i < NUM_IRQS; i++) begin
      for (int l = 0; l < NUM_LINKS; l++) begin
        if (link_live[l] && (32'(routes[l].num) == i)) irq_next[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_out <= '0;
    else        irq_out <= irq_next;
  end
endmodule

// File: rtl/irq_link_router.sv
module irq_link_router
  import irq_router_pkg::*;
#(
  parameter int unsigned         NUM_LINKS     = 8,
  parameter int unsigned         REQS_PER_LINK = 4,
  parameter int unsigned         NUM_IRQS      = 16,
  parameter logic [NUM_IRQS-1:0] PERMIT_MASK   = 16'hDEF8,
  localparam int unsigned        IDX_W         = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1,
  localparam int unsigned        REQ_W         = NUM_LINKS * REQS_PER_LINK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic              cfg_rd_en,
  input  logic [IDX_W-1:0]  cfg_link,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic [REQ_W-1:0]  dev_req,
  output logic [NUM_IRQS-1:0] irq_out
);
  route_t [NUM_LINKS-1:0] routes;
  logic   [NUM_LINKS-1:0] link_active;

  irq_route_regs #(.NUM_LINKS(NUM_LINKS)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_wr_en),
    .rd_en  (cfg_rd_en),
    .idx    (cfg_link),
    .wdata  (cfg_wdata),
    .rdata  (cfg_rdata),
    .routes (routes)
  );

  irq_link_activity #(
    .NUM_LINKS     (NUM_LINKS),
    .REQS_PER_LINK (REQS_PER_LINK)
  ) u_act (
    .dev_req     (dev_req),
    .link_active (link_active)
  );

  irq_line_fanout #(
    .NUM_LINKS   (NUM_LINKS),
    .NUM_IRQS    (NUM_IRQS),
    .PERMIT_MASK (PERMIT_MASK)
  ) u_fan (
    .clk         (clk),
    .rst_n       (rst_n),
    .routes      (routes),
    .link_active (link_active),
    .irq_out     (irq_out)
  );
endmodule

// File: rtl/irq_link_router_chk.sv
module irq_link_router_chk #(
  parameter int unsigned         NUM_IRQS    = 16,
  parameter int unsigned         REQ_W       = 32,
  parameter logic [NUM_IRQS-1:0] PERMIT_MASK = 16'hDEF8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_rd_en,
  input logic [7:0]          cfg_rdata,
  input logic [REQ_W-1:0]    dev_req,
  input logic [NUM_IRQS-1:0] irq_out
);
  AST_RDATA_GAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[6:4] == 3'b000); // R2

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_rd_en) |-> $stable(cfg_rdata)); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dev_req) == '0) |-> (irq_out == '0)); // R4

  AST_RESERVED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out & ~PERMIT_MASK) == '0); // R5

  AST_LINE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_out) <= $countones($past(dev_req))); // R7
endmodule

bind irq_link_router irq_link_router_chk #(
  .NUM_IRQS    (NUM_IRQS),
  .REQ_W       (REQ_W),
  .PERMIT_MASK (PERMIT_MASK)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_rd_en (cfg_rd_en),
  .cfg_rdata (cfg_rdata),
  .dev_req   (dev_req),
  .irq_out   (irq_out)
);

// File: tb/irq_link_router_tb.sv
`timescale 1ns/1ps
module irq_link_router_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic        cfg_rd_en = 1'b0;
  logic [2:0]  cfg_link = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic [31:0] dev_req = '0;
  logic [15:0] irq_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_link_router u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en),
    .cfg_link(cfg_link), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .dev_req(dev_req), .irq_out(irq_out)
  );

  localparam int NROW = 9;
  localparam logic [2:0]  T_LINK [NROW] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7, 3'd7};
  localparam logic [7:0]  T_WR   [NROW] = '{8'h05, 8'h0E, 8'h08, 8'h83, 8'h7B, 8'h00, 8'h0F, 8'h03, 8'h0D};
  localparam logic [7:0]  T_RD   [NROW] = '{8'h05, 8'h0E, 8'h08, 8'h83, 8'h0B, 8'h00, 8'h0F, 8'h03, 8'h0D};
  localparam logic [31:0] T_REQ  [NROW] = '{32'h0000_0001, 32'h0000_0080, 32'h0000_0100,
                                           32'h0000_1000, 32'h0002_0000, 32'h00F0_0000,
                                           32'h0400_0000, 32'h8000_0000, 32'h1000_0000};
  localparam logic [15:0] T_IRQ  [NROW] = '{16'h0020, 16'h4000, 16'h0000, 16'h0000, 16'h0800,
                                           16'h0000, 16'h8000, 16'h0008, 16'h0000};

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] l, input logic [7:0] d);
    cfg_wr_en = 1'b1; cfg_link = l; cfg_wdata = d;
    @(posedge clk); @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] l, output logic [7:0] d);
    cfg_rd_en = 1'b1; cfg_link = l;
    @(posedge clk); @(negedge clk);
    cfg_rd_en = 1'b0;
    d = cfg_rdata;
  endtask

  task automatic settle();
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] rv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", irq_out, 16'h0000);
    for (int l = 0; l < 8; l++) begin
      rd(3'(l), rv);
      check("R1 route", {8'h00, rv}, 16'h0080);
    end

    // Table walk: R2..R6
    for (int r = 0; r < NROW; r++) begin
      dev_req = '0;
      wr(T_LINK[r], T_WR[r]);
      rd(T_LINK[r], rv);
      check("R2 readback", {8'h00, rv}, {8'h00, T_RD[r]});
      dev_req = T_REQ[r];
      settle();
      check("R4/R5/R6 table", irq_out, T_IRQ[r]);
    end
    dev_req = '0;
    settle();

    // R2 read data holds without a read strobe
    rd(3'd4, rv);
    wr(3'd4, 8'h09);
    settle();
    check("R2 hold", {8'h00, cfg_rdata}, 16'h000B);

    // R3 each requester of link 0 (routed to irq 5)
    for (int b = 0; b < 4; b++) begin
      dev_req = 32'(1) << b;
      settle();
      check("R3 single requester", irq_out, 16'h0020);
    end
    // R3 release only on last requester
    dev_req = 32'h3; settle();
    dev_req = 32'h2; settle();
    check("R3 one left", irq_out, 16'h0020);
    dev_req = 32'h0; settle();
    check("R3 last dropped", irq_out, 16'h0000);

    // R6 disable with valid target
    wr(3'd0, 8'h85);
    dev_req = 32'h1; settle();
    check("R6 disabled", irq_out, 16'h0000);
    dev_req = '0;

    // R7 sharing: links 0 and 1 on irq 9
    wr(3'd0, 8'h09);
    wr(3'd1, 8'h09);
    dev_req = 32'h11; settle();
    check("R7 both", irq_out, 16'h0200);
    dev_req = 32'h10; settle();
    check("R7 one remains", irq_out, 16'h0200);
    dev_req = 32'h00; settle();
    check("R7 none", irq_out, 16'h0000);

    // R8 retarget: link 2 active on irq 4, move to irq 12
    wr(3'd2, 8'h04);
    dev_req = 32'h100; settle();
    check("R8 before", irq_out, 16'h0010);
    wr(3'd2, 8'h0C);
    check("R8 old still", irq_out, 16'h0010);
    @(posedge clk); @(negedge clk);
    check("R8 moved", irq_out, 16'h1000);
    wr(3'd2, 8'h0D); settle();
    check("R8 to reserved", irq_out, 16'h0000);
    wr(3'd2, 8'h06); settle();
    check("R8 from reserved", irq_out, 16'h0040);
    wr(3'd2, 8'h80); settle();
    check("R8 to disabled", irq_out, 16'h0000);

    // R9 rewrite same value while active
    wr(3'd2, 8'h07); settle();
    check("R9 before", irq_out, 16'h0080);
    cfg_wr_en = 1'b1; cfg_link = 3'd2; cfg_wdata = 8'h07;
    for (int c = 0; c < 3; c++) begin
      @(posedge clk); @(negedge clk);
      check("R9 unchanged", irq_out, 16'h0080);
    end
    cfg_wr_en = 1'b0;
    dev_req = '0;
    settle();

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule